// File: doc/BRIEF.md
# DRAM Controller Register Stub

This block is a 32-bit memory-mapped register slave that takes the place of a DRAM controller while boot firmware is brought up. It holds the three registers firmware touches during memory initialisation: a control/configuration register, an impedance-calibration control register and an impedance-calibration status register. Every long-running operation that firmware can start appears to be finished at once. Start bits in the control register are stored as zero on the same write that sets them. Any write to the calibration control register raises the calibration-done flag in the status register. Polling loops therefore end on their first read.

The bus is word-addressed. `bus_addr` carries the word index, which is the byte offset divided by four, and only full 32-bit accesses exist. Each access falls into one of five decode regions. `RGN_CTRL` is word 0x00 (byte 0x000). `RGN_ZQCTL` is word 0x2A (byte 0x0A8). `RGN_ZQSTAT` is word 0x2C (byte 0x0B0). `RGN_OOR` covers word `OOR_FIRST` (default 0xB9, byte 0x2E4) up to the end of the window. `RGN_HOLE` covers every other word. There is one datapath state per register, and no sequencing state: a register moves from its reset value to its written value in the clock edge after the write. A synchronous reset brings it back.

A read returns its data through a register, one clock after the read strobe. For a write that lands in a hole or outside the range, the block raises a one-cycle diagnostic pulse, so a testbench can see how the address was decoded.

Top module: `dramstub_regblk`

## Requirements
- R1: After reset, the control register reads 0x80020000, the calibration control register reads 0x07B00000 and the calibration status register reads 0x80000000, and `bus_rdata` is 0.
- R2: A write to word 0x00 stores bit 31 (initialisation start) as 0 and keeps every other written bit except bit 30.
- R3: A write to word 0x00 stores bit 30 (training start) as 0 and keeps every other written bit except bit 31.
- R4: A write to word 0x2A stores the written value and sets bit 31 (calibration done) of the status register at word 0x2C, leaving status bits 30..0 unchanged.
- R5: A write to word 0x2C stores the written value as the new status.
- R6: A read of a hole word (below `OOR_FIRST`, not 0x00, 0x2A or 0x2C) returns 0.
- R7: A read of any word from `OOR_FIRST` to the top of the window returns 0.
- R8: Writes to hole or out-of-range words leave all three implemented registers unchanged.
- R9: `wr_hole_pulse` is high for exactly the one cycle after a write to a hole word, and it is low otherwise.
- R10: `wr_oor_pulse` is high for exactly the one cycle after a write to an out-of-range word, and it is low otherwise.
- R11: `bus_rdata` takes its new value on the clock edge that samples `bus_rd` and holds that value while `bus_rd` stays low. A read and a write in the same cycle return the value from before the write.
- R12: Asserting `rst` synchronously in the middle of operation restores all three registers to their R1 values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | IDX_W | Word index of the access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| wr_hole_pulse | output | 1 | One-cycle pulse after a write to a hole word |
| wr_oor_pulse | output | 1 | One-cycle pulse after a write to an out-of-range word |

## Verification
The bench builds the block with the default parameters: `IDX_W` = 10 (a 1024-word window) and `OOR_FIRST` = 0xB9. With these values the hole/out-of-range boundary can be probed from both sides, at words 0xB8 and 0xB9, and the very top of the window at word 0x3FF is reachable too. The implemented words sit at their fixed indices, so the bench also covers writes to the hole words next to them, the same-cycle read and write of the status register, and a reset issued after the registers have been changed.

// File: rtl/dramstub_pkg.sv
package dramstub_pkg;

    localparam int unsigned WORD_W = 32;

    // Word indices (byte offset / 4) of the implemented registers.
    localparam int unsigned IDX_CTRL   = 'h00;
    localparam int unsigned IDX_ZQCTL  = 'h2A;
    localparam int unsigned IDX_ZQSTAT = 'h2C;

    // Bit positions with behaviour attached.
    localparam int unsigned BIT_INIT_GO  = 31;
    localparam int unsigned BIT_TRAIN_GO = 30;
    localparam int unsigned BIT_ZQ_DONE  = 31;

    // Reset contents.
    localparam logic [WORD_W-1:0] RST_CTRL   = 32'h8002_0000;
    localparam logic [WORD_W-1:0] RST_ZQCTL  = 32'h07B0_0000;
    localparam logic [WORD_W-1:0] RST_ZQSTAT = 32'h8000_0000;

    typedef enum logic [2:0] {
        RGN_CTRL,
        RGN_ZQCTL,
        RGN_ZQSTAT,
        RGN_HOLE,
        RGN_OOR
    } region_e;

endpackage

// File: rtl/dramstub_decode.sv
module dramstub_decode
    import dramstub_pkg::*;
#(
    parameter int unsigned IDX_W     = 10,
    parameter int unsigned OOR_FIRST = 'hB9
) (
    input  logic [IDX_W-1:0] idx,
    output region_e          region
);

    localparam logic [IDX_W-1:0] L_CTRL   = IDX_W'(IDX_CTRL);
    localparam logic [IDX_W-1:0] L_ZQCTL  = IDX_W'(IDX_ZQCTL);
    localparam logic [IDX_W-1:0] L_ZQSTAT = IDX_W'(IDX_ZQSTAT);

    always_comb begin
        if (32'(idx) >= OOR_FIRST) begin
            region = RGN_OOR;
        end else begin
            unique case (idx)
                L_CTRL:   region = RGN_CTRL;
                L_ZQCTL:  region = RGN_ZQCTL;
                L_ZQSTAT: region = RGN_ZQSTAT;
                default:  region = RGN_HOLE;
            endcase
        end
    end

endmodule

// File: rtl/dramstub_regs.sv
module dramstub_regs
    import dramstub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  region_e           region,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] zqctl_q,
    output logic [WORD_W-1:0] zqstat_q
);

    localparam logic [WORD_W-1:0] GO_MASK =
        (WORD_W'(1) << BIT_INIT_GO) | (WORD_W'(1) << BIT_TRAIN_GO);
    localparam logic [WORD_W-1:0] DONE_MASK = WORD_W'(1) << BIT_ZQ_DONE;

    logic [WORD_W-1:0] ctrl_d, zqctl_d, zqstat_d;

    always_comb begin
        ctrl_d   = ctrl_q;
        zqctl_d  = zqctl_q;
        zqstat_d = zqstat_q;
        if (wr) begin
            unique case (region)
                RGN_CTRL:   ctrl_d   = wdata & ~GO_MASK;
                RGN_ZQCTL: begin
                    zqctl_d  = wdata;
                    zqstat_d = zqstat_q | DONE_MASK;
                end
                RGN_ZQSTAT: zqstat_d = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= RST_CTRL;
            zqctl_q  <= RST_ZQCTL;
            zqstat_q <= RST_ZQSTAT;
        end else begin
            ctrl_q   <= ctrl_d;
            zqctl_q  <= zqctl_d;
            zqstat_q <= zqstat_d;
        end
    end

    assert_reset_values_R1: assert property (@(posedge clk)
        rst |=> (ctrl_q == RST_CTRL && zqctl_q == RST_ZQCTL && zqstat_q == RST_ZQSTAT));

    assert_init_go_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && region == RGN_CTRL) |=> !ctrl_q[BIT_INIT_GO]);

    assert_train_go_clears_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && region == RGN_CTRL) |=> !ctrl_q[BIT_TRAIN_GO]);

    assert_zq_done_sets_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && region == RGN_ZQCTL) |=> zqstat_q[BIT_ZQ_DONE]);

    assert_zq_other_bits_R4: assert property (@(posedge clk) disable iff (rst)
        (wr && region == RGN_ZQCTL) |=> zqstat_q[BIT_ZQ_DONE-1:0] == $past(zqstat_q[BIT_ZQ_DONE-1:0]));

    assert_status_write_R5: assert property (@(posedge clk) disable iff (rst)
        (wr && region == RGN_ZQSTAT) |=> zqstat_q == $past(wdata));

    assert_stray_write_inert_R8: assert property (@(posedge clk) disable iff (rst)
        (wr && (region == RGN_HOLE || region == RGN_OOR))
        |=> ($stable(ctrl_q) && $stable(zqctl_q) && $stable(zqstat_q)));

endmodule

// File: rtl/dramstub_rdport.sv
module dramstub_rdport
    import dramstub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  region_e           region,
    input  logic [WORD_W-1:0] ctrl_q,
    input  logic [WORD_W-1:0] zqctl_q,
    input  logic [WORD_W-1:0] zqstat_q,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] sel_word;

    always_comb begin
        unique case (region)
            RGN_CTRL:   sel_word = ctrl_q;
            RGN_ZQCTL:  sel_word = zqctl_q;
            RGN_ZQSTAT: sel_word = zqstat_q;
            default:    sel_word = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd) begin
            rdata <= sel_word;
        end
    end

    assert_hole_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
        (rd && region == RGN_HOLE) |=> rdata == '0);

    assert_oor_reads_zero_R7: assert property (@(posedge clk) disable iff (rst)
        (rd && region == RGN_OOR) |=> rdata == '0);

    assert_status_read_old_R11: assert property (@(posedge clk) disable iff (rst)
        (rd && region == RGN_ZQSTAT) |=> rdata == $past(zqstat_q));

endmodule

// File: rtl/dramstub_regblk.sv
module dramstub_regblk
    import dramstub_pkg::*;
#(
    parameter int unsigned IDX_W     = 10,
    parameter int unsigned OOR_FIRST = 'hB9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              wr_hole_pulse,
    output logic              wr_oor_pulse
);

    region_e           region;
    logic [WORD_W-1:0] ctrl_q, zqctl_q, zqstat_q;

    dramstub_decode #(.IDX_W(IDX_W), .OOR_FIRST(OOR_FIRST)) u_decode (
        .idx    (bus_addr),
        .region (region)
    );

    dramstub_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .region   (region),
        .wdata    (bus_wdata),
        .ctrl_q   (ctrl_q),
        .zqctl_q  (zqctl_q),
        .zqstat_q (zqstat_q)
    );

    dramstub_rdport u_rdport (
        .clk      (clk),
        .rst      (rst),
        .rd       (bus_rd),
        .region   (region),
        .ctrl_q   (ctrl_q),
        .zqctl_q  (zqctl_q),
        .zqstat_q (zqstat_q),
        .rdata    (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_hole_pulse <= 1'b0;
            wr_oor_pulse  <= 1'b0;
        end else begin
            wr_hole_pulse <= bus_wr && (region == RGN_HOLE);
            wr_oor_pulse  <= bus_wr && (region == RGN_OOR);
        end
    end

    assert_pulses_exclusive_R9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_hole_pulse, wr_oor_pulse}));

    assert_hole_pulse_cause_R9: assert property (@(posedge clk) disable iff (rst)
        wr_hole_pulse |-> ($past(bus_wr) && 32'($past(bus_addr)) < OOR_FIRST));

    assert_oor_pulse_cause_R10: assert property (@(posedge clk) disable iff (rst)
        wr_oor_pulse |-> ($past(bus_wr) && 32'($past(bus_addr)) >= OOR_FIRST));

    assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/tb_dramstub_regblk.sv
module tb_dramstub_regblk;

    localparam int unsigned IDX_W = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [IDX_W-1:0] bus_addr = '0;
    logic [31:0]      bus_wdata = '0;
    logic             bus_wr = 1'b0;
    logic             bus_rd = 1'b0;
    logic [31:0]      bus_rdata;
    logic             wr_hole_pulse, wr_oor_pulse;

    int tests = 0;
    int fails = 0;

    logic hole_seen, oor_seen;

    always #2 clk = ~clk;

    dramstub_regblk #(.IDX_W(IDX_W), .OOR_FIRST('hB9)) dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .wr_hole_pulse(wr_hole_pulse), .wr_oor_pulse(wr_oor_pulse)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [IDX_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        hole_seen = wr_hole_pulse;
        oor_seen  = wr_oor_pulse;
        bus_wr = 1'b0;
    endtask

    task automatic do_read(input logic [IDX_W-1:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0;
    endtask

    task automatic check_defaults(input string req);
        logic [31:0] v;
        do_read(10'h000, v); chk(req, v, 32'h8002_0000);
        do_read(10'h02A, v); chk(req, v, 32'h07B0_0000);
        do_read(10'h02C, v); chk(req, v, 32'h8000_0000);
    endtask

    task automatic t_reset;
        chk("R1 rdata at reset", bus_rdata, 32'h0);
        check_defaults("R1");
    endtask

    task automatic t_start_bits;
        logic [31:0] v;
        do_write(10'h000, 32'hC000_1234); do_read(10'h000, v); chk("R2/R3 both go", v, 32'h0000_1234);
        do_write(10'h000, 32'h8000_0055); do_read(10'h000, v); chk("R2 init go", v, 32'h0000_0055);
        do_write(10'h000, 32'h4000_0077); do_read(10'h000, v); chk("R3 train go", v, 32'h0000_0077);
        do_write(10'h000, 32'h2ABC_DEF0); do_read(10'h000, v); chk("R2 keep bits", v, 32'h2ABC_DEF0);
        chk("R9 no hole pulse on ctrl", {31'b0, hole_seen}, 32'h0);
        chk("R10 no oor pulse on ctrl", {31'b0, oor_seen}, 32'h0);
    endtask

    task automatic t_calibration;
        logic [31:0] v;
        do_write(10'h02C, 32'h0000_0005); do_read(10'h02C, v); chk("R5 status write", v, 32'h0000_0005);
        do_write(10'h02A, 32'h1234_5678);
        do_read(10'h02A, v); chk("R4 zq ctrl stored", v, 32'h1234_5678);
        do_read(10'h02C, v); chk("R4 done flag", v, 32'h8000_0005);
    endtask

    task automatic t_same_cycle;
        logic [31:0] v;
        @(negedge clk);
        bus_addr = 10'h02C; bus_wdata = 32'h0000_000A; bus_wr = 1'b1; bus_rd = 1'b1;
        @(negedge clk);
        v = bus_rdata;
        bus_wr = 1'b0; bus_rd = 1'b0;
        chk("R11 read before write", v, 32'h8000_0005);
        repeat (3) @(negedge clk);
        chk("R11 rdata holds", bus_rdata, 32'h8000_0005);
        do_read(10'h02C, v); chk("R5 status after same-cycle", v, 32'h0000_000A);
    endtask

    task automatic t_holes;
        logic [31:0] v;
        do_write(10'h001, 32'hFFFF_FFFF);
        chk("R9 hole pulse", {31'b0, hole_seen}, 32'h1);
        chk("R10 no oor on hole", {31'b0, oor_seen}, 32'h0);
        @(negedge clk);
        chk("R9 pulse one cycle", {31'b0, wr_hole_pulse}, 32'h0);
        do_read(10'h001, v); chk("R6 hole reads 0", v, 32'h0);
        do_write(10'h0B8, 32'hDEAD_BEEF);
        chk("R9 hole at 0xB8", {31'b0, hole_seen}, 32'h1);
        do_read(10'h0B8, v); chk("R6 hole 0xB8 reads 0", v, 32'h0);
        do_read(10'h02B, v); chk("R6 hole 0x2B reads 0", v, 32'h0);
    endtask

    task automatic t_oor;
        logic [31:0] v;
        do_write(10'h0B9, 32'hFFFF_FFFF);
        chk("R10 oor pulse 0xB9", {31'b0, oor_seen}, 32'h1);
        chk("R9 no hole on oor", {31'b0, hole_seen}, 32'h0);
        do_write(10'h3FF, 32'h1111_1111);
        chk("R10 oor pulse 0x3FF", {31'b0, oor_seen}, 32'h1);
        do_read(10'h0B9, v); chk("R7 oor 0xB9 reads 0", v, 32'h0);
        do_read(10'h3FF, v); chk("R7 oor 0x3FF reads 0", v, 32'h0);
    endtask

    task automatic t_stray_inert;
        logic [31:0] v;
        do_read(10'h000, v); chk("R8 ctrl unchanged", v, 32'h2ABC_DEF0);
        do_read(10'h02A, v); chk("R8 zq ctrl unchanged", v, 32'h1234_5678);
        do_read(10'h02C, v); chk("R8 status unchanged", v, 32'h0000_000A);
    endtask

    task automatic t_midrun_reset;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check_defaults("R12");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_start_bits();
        t_calibration();
        t_same_cycle();
        t_holes();
        t_oor();
        t_stray_inert();
        t_midrun_reset();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule